// File: doc/BRIEF.md
# Delayed Read Tracker with Requester Tags

This block sits on the target side of a shared parallel bus and handles reads that the target cannot answer at once. The first time a read arrives, the tracker stores its address, command and a requester tag in a small table, and it answers with retry. The tag is the index of the master whose grant line is active. The back end receives the stored request, services it, and returns the read data into the same table slot. When the master later repeats the read, the stored data is handed over together with a complete response.

A stored result goes only to the master that started it. A repeat with the same address and command from any other master gets retry and leaves the stored data in place. For initiators that do not take part in tagging, a configuration input turns off the tag comparison. Writes are accepted at once and never wait behind stored read data. Each stored result has a timer that discards it if it is not claimed in time, and a sticky flag records that a discard has happened.

Top module: `dtt_tracker`

## Requirements
- R1: The requester tag is the bit index of the single low bit in the active-low grant vector `gnt_n` when the request starts (bit 0 is master 0).
- R2: If `gnt_n` has no low bit or more than one low bit during a request, `tag_err` is high in that cycle and the request is handled with tag 0.
- R3: A read that matches no table slot gets `rsp_retry` in the same cycle and takes the lowest-numbered free slot. That slot then waits to be offered to the back end.
- R4: A read that matches a slot holding returned data (same address, command and tag) gets `rsp_done` with `rsp_data_valid` and the stored word on `rsp_data` in the same cycle. `rsp_done` and `rsp_retry` are never high together.
- R5: A read with the same address and command but another tag does not receive the stored data. It gets retry and is treated as a new request.
- R6: While `ignore_tag` is high, matching uses only address and command, so any master can claim the stored data.
- R7: A write (`req_write` high) gets `rsp_done` in the same cycle without touching the table, even while stored read data is waiting.
- R8: A repeated read that matches a slot whose data has not yet returned gets retry and takes no second slot.
- R9: When all slots are in use, a read that matches none of them gets retry and no slot is allocated.
- R10: Returned data that is not claimed within TIMEOUT cycles after its capture edge is dropped, and the slot is freed. `discard_flag` then goes high and stays high until reset.
- R11: A slot whose data was claimed is free from the next clock edge, so the same read repeated afterwards starts a new request.
- R12: `be_req_valid`/`be_req_idx` present the lowest-numbered slot that has not yet been sent to the back end. When `be_req_ready` is high, that slot counts as sent. `be_cpl_valid` with `be_cpl_idx` stores `be_cpl_data` into a sent slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ignore_tag | input | 1 | Match on address and command only |
| req_valid | input | 1 | A bus request starts this cycle |
| req_write | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Request address |
| req_cmd | input | CMD_W | Request command |
| gnt_n | input | NUM_MASTERS | Active-low grant lines from the arbiter |
| rsp_retry | output | 1 | Respond with retry |
| rsp_done | output | 1 | Respond with completion |
| rsp_data_valid | output | 1 | `rsp_data` carries stored read data |
| rsp_data | output | DATA_W | Stored read data |
| tag_err | output | 1 | Grant vector was not one-hot for this request |
| discard_flag | output | 1 | Sticky: stored data was dropped by timeout |
| be_req_valid | output | 1 | A slot waits to be sent to the back end |
| be_req_idx | output | $clog2(DEPTH) | Slot index offered to the back end |
| be_req_addr | output | ADDR_W | Address of the offered slot |
| be_req_cmd | output | CMD_W | Command of the offered slot |
| be_req_ready | input | 1 | Back end takes the offered slot |
| be_cpl_valid | input | 1 | Back end returns data |
| be_cpl_idx | input | $clog2(DEPTH) | Slot that receives the returned data |
| be_cpl_data | input | DATA_W | Returned read word |

## Verification
The bench builds the tracker with 16 masters, a 4-slot table and TIMEOUT set to 40 cycles. The 16 grant lines exercise the full 4-bit tag range. With only four slots, a handful of reads fills the table. The short timeout lets several stored results expire during an idle stretch, with the sticky flag observed before and after the expiry. A behavioural model follows the table and predicts every response, tag error, back-end offer and the discard flag on each cycle.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_SENT = 2'd2,
        SLOT_DONE = 2'd3
    } slot_state_e;
endpackage

// File: rtl/dtt_grant_enc.sv
module dtt_grant_enc #(
    parameter int NUM_MASTERS = 16,
    parameter int TAG_W       = $clog2(NUM_MASTERS)
) (
    input  logic [NUM_MASTERS-1:0] gnt_n,
    output logic [TAG_W-1:0]       tag,
    output logic                   err
);
    localparam int CNT_W = $clog2(NUM_MASTERS + 1);

    logic [CNT_W-1:0] low_cnt;
    logic [TAG_W-1:0] idx;

    always_comb begin
        low_cnt = '0;
        idx     = '0;
        for (int i = NUM_MASTERS - 1; i >= 0; i--) begin
            if (!gnt_n[i]) begin
                low_cnt = low_cnt + 1'b1;
                idx     = TAG_W'(i);
            end
        end
        err = (low_cnt != CNT_W'(1));
        tag = err ? '0 : idx;
    end
endmodule

// File: rtl/dtt_slot.sv
module dtt_slot
    import dtt_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CMD_W   = 4,
    parameter int TAG_W   = 4,
    parameter int DATA_W  = 32,
    parameter int TIMEOUT = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic              issue_i,
    input  logic              cpl_i,
    input  logic              claim_i,
    input  logic              ignore_tag,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [DATA_W-1:0] cpl_data,
    output logic              busy_o,
    output logic              wait_o,
    output logic              done_o,
    output logic              hit_o,
    output logic              expire_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int TMR_W = $clog2(TIMEOUT + 1);

    typedef struct packed {
        slot_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
        logic [TMR_W-1:0]  tmr;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        hit_o    = (s_q.st != SLOT_FREE) && (s_q.addr == req_addr) &&
                   (s_q.cmd == req_cmd) && (ignore_tag || (s_q.tag == req_tag));
        expire_o = (s_q.st == SLOT_DONE) && (s_q.tmr == TMR_W'(TIMEOUT - 1)) && !claim_i;
        unique case (s_q.st)
            SLOT_FREE: if (alloc_i) begin
                s_d.st   = SLOT_WAIT;
                s_d.addr = req_addr;
                s_d.cmd  = req_cmd;
                s_d.tag  = req_tag;
                s_d.tmr  = '0;
            end
            SLOT_WAIT: if (issue_i) s_d.st = SLOT_SENT;
            SLOT_SENT: if (cpl_i) begin
                s_d.st   = SLOT_DONE;
                s_d.data = cpl_data;
                s_d.tmr  = '0;
            end
            SLOT_DONE: begin
                if (claim_i || expire_o) s_d.st = SLOT_FREE;
                else                     s_d.tmr = s_q.tmr + 1'b1;
            end
            default: s_d.st = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= SLOT_FREE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.st != SLOT_FREE);
    assign wait_o = (s_q.st == SLOT_WAIT);
    assign done_o = (s_q.st == SLOT_DONE);
    assign addr_o = s_q.addr;
    assign cmd_o  = s_q.cmd;
    assign data_o = s_q.data;
endmodule

// File: rtl/dtt_tracker.sv
module dtt_tracker #(
    parameter int NUM_MASTERS = 16,
    parameter int DEPTH       = 4,
    parameter int ADDR_W      = 16,
    parameter int CMD_W       = 4,
    parameter int DATA_W      = 32,
    parameter int TIMEOUT     = 32768,
    localparam int TAG_W      = $clog2(NUM_MASTERS),
    localparam int IDX_W      = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ignore_tag,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [CMD_W-1:0]       req_cmd,
    input  logic [NUM_MASTERS-1:0] gnt_n,
    output logic                   rsp_retry,
    output logic                   rsp_done,
    output logic                   rsp_data_valid,
    output logic [DATA_W-1:0]      rsp_data,
    output logic                   tag_err,
    output logic                   discard_flag,
    output logic                   be_req_valid,
    output logic [IDX_W-1:0]       be_req_idx,
    output logic [ADDR_W-1:0]      be_req_addr,
    output logic [CMD_W-1:0]       be_req_cmd,
    input  logic                   be_req_ready,
    input  logic                   be_cpl_valid,
    input  logic [IDX_W-1:0]       be_cpl_idx,
    input  logic [DATA_W-1:0]      be_cpl_data
);
    typedef struct packed {
        logic discard;
    } top_t;

    top_t top_d, top_q;

    logic [TAG_W-1:0] req_tag;
    logic             enc_err;

    logic [DEPTH-1:0] busy_v, wait_v, done_v, hit_v, exp_v;
    logic [DEPTH-1:0] alloc_v, issue_v, cpl_v, claim_v;
    logic [ADDR_W-1:0] slot_addr [DEPTH];
    logic [CMD_W-1:0]  slot_cmd  [DEPTH];
    logic [DATA_W-1:0] slot_data [DEPTH];

    logic             rd_req, hit_any, free_any, wait_any, claim_ok;
    logic [IDX_W-1:0] hit_idx, free_idx, wait_idx;

    dtt_grant_enc #(.NUM_MASTERS(NUM_MASTERS), .TAG_W(TAG_W)) u_enc (
        .gnt_n (gnt_n),
        .tag   (req_tag),
        .err   (enc_err)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        dtt_slot #(
            .ADDR_W(ADDR_W), .CMD_W(CMD_W), .TAG_W(TAG_W),
            .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (alloc_v[g]),
            .issue_i    (issue_v[g]),
            .cpl_i      (cpl_v[g]),
            .claim_i    (claim_v[g]),
            .ignore_tag (ignore_tag),
            .req_addr   (req_addr),
            .req_cmd    (req_cmd),
            .req_tag    (req_tag),
            .cpl_data   (be_cpl_data),
            .busy_o     (busy_v[g]),
            .wait_o     (wait_v[g]),
            .done_o     (done_v[g]),
            .hit_o      (hit_v[g]),
            .expire_o   (exp_v[g]),
            .addr_o     (slot_addr[g]),
            .cmd_o      (slot_cmd[g]),
            .data_o     (slot_data[g])
        );
    end

    always_comb begin
        rd_req   = req_valid && !req_write;
        hit_any  = 1'b0;
        free_any = 1'b0;
        wait_any = 1'b0;
        hit_idx  = '0;
        free_idx = '0;
        wait_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_v[i])   begin hit_any  = 1'b1; hit_idx  = IDX_W'(i); end
            if (!busy_v[i]) begin free_any = 1'b1; free_idx = IDX_W'(i); end
            if (wait_v[i])  begin wait_any = 1'b1; wait_idx = IDX_W'(i); end
        end
        claim_ok = rd_req && hit_any && done_v[hit_idx];
        for (int i = 0; i < DEPTH; i++) begin
            claim_v[i] = claim_ok && (hit_idx == IDX_W'(i));
            alloc_v[i] = rd_req && !hit_any && free_any && (free_idx == IDX_W'(i));
            issue_v[i] = be_req_ready && wait_any && (wait_idx == IDX_W'(i));
            cpl_v[i]   = be_cpl_valid && (be_cpl_idx == IDX_W'(i));
        end
        top_d.discard = top_q.discard || (|exp_v);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign rsp_done       = (req_valid && req_write) || claim_ok;
    assign rsp_retry      = rd_req && !claim_ok;
    assign rsp_data_valid = claim_ok;
    assign rsp_data       = claim_ok ? slot_data[hit_idx] : '0;
    assign tag_err        = req_valid && enc_err;
    assign discard_flag   = top_q.discard;
    assign be_req_valid   = wait_any;
    assign be_req_idx     = wait_idx;
    assign be_req_addr    = slot_addr[wait_idx];
    assign be_req_cmd     = slot_cmd[wait_idx];
endmodule

// File: rtl/dtt_tracker_chk.sv
module dtt_tracker_chk #(
    parameter int NUM_MASTERS = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_write,
    input logic [NUM_MASTERS-1:0] gnt_n,
    input logic                   rsp_retry,
    input logic                   rsp_done,
    input logic                   rsp_data_valid,
    input logic                   tag_err,
    input logic                   discard_flag
);
    p_done_retry_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_done && rsp_retry));

    p_data_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_data_valid |-> (rsp_done && req_valid && !req_write));

    p_write_accepted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> (rsp_done && !rsp_data_valid));

    p_read_answered_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> (rsp_done || rsp_retry));

    p_idle_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!rsp_done && !rsp_retry && !tag_err));

    p_bad_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ($countones(gnt_n) != NUM_MASTERS - 1)) |-> tag_err);

    p_good_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ($countones(gnt_n) == NUM_MASTERS - 1)) |-> !tag_err);

    p_discard_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        discard_flag |=> discard_flag);
endmodule

bind dtt_tracker dtt_tracker_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .gnt_n          (gnt_n),
    .rsp_retry      (rsp_retry),
    .rsp_done       (rsp_done),
    .rsp_data_valid (rsp_data_valid),
    .tag_err        (tag_err),
    .discard_flag   (discard_flag)
);

// File: tb/dtt_tracker_bench.sv
`timescale 1ns/1ps
module dtt_tracker_bench;
    localparam int NM = 16;
    localparam int DP = 4;
    localparam int AW = 16;
    localparam int CW = 4;
    localparam int DW = 32;
    localparam int TO = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ignore_tag = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_cmd = '0;
    logic [NM-1:0] gnt_n = '1;
    logic          rsp_retry, rsp_done, rsp_data_valid, tag_err, discard_flag;
    logic [DW-1:0] rsp_data;
    logic          be_req_valid;
    logic [1:0]    be_req_idx;
    logic [AW-1:0] be_req_addr;
    logic [CW-1:0] be_req_cmd;
    logic          be_req_ready = 1'b0;
    logic          be_cpl_valid = 1'b0;
    logic [1:0]    be_cpl_idx = '0;
    logic [DW-1:0] be_cpl_data = '0;

    always #10 clk = ~clk;

    dtt_tracker #(.NUM_MASTERS(NM), .DEPTH(DP), .ADDR_W(AW), .CMD_W(CW),
                  .DATA_W(DW), .TIMEOUT(TO)) u_dtt_tracker (
        .clk(clk), .rst_n(rst_n), .ignore_tag(ignore_tag),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_cmd(req_cmd), .gnt_n(gnt_n), .rsp_retry(rsp_retry),
        .rsp_done(rsp_done), .rsp_data_valid(rsp_data_valid),
        .rsp_data(rsp_data), .tag_err(tag_err), .discard_flag(discard_flag),
        .be_req_valid(be_req_valid), .be_req_idx(be_req_idx),
        .be_req_addr(be_req_addr), .be_req_cmd(be_req_cmd),
        .be_req_ready(be_req_ready), .be_cpl_valid(be_cpl_valid),
        .be_cpl_idx(be_cpl_idx), .be_cpl_data(be_cpl_data)
    );

    int checks = 0;
    int errors = 0;
    string lbl = "reset";

    // reference model: 0 free, 1 waiting, 2 sent, 3 holding data
    int m_st [DP], m_addr [DP], m_cmd [DP], m_tag [DP], m_tmr [DP];
    logic [DW-1:0] m_data [DP];
    int n_st [DP], n_addr [DP], n_cmd [DP], n_tag [DP], n_tmr [DP];
    logic [DW-1:0] n_data [DP];
    bit m_disc = 0, n_disc = 0;

    task automatic chk(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", lbl, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            int lows, tg, hit, frees, waits;
            bit bad, rd, take;
            lows = 0; tg = 0;
            for (int i = 0; i < NM; i++) if (!gnt_n[i]) begin lows++; tg = i; end
            bad = (lows != 1);
            if (bad) tg = 0;
            rd = req_valid && !req_write;
            hit = -1; frees = -1; waits = -1;
            for (int i = DP - 1; i >= 0; i--) begin
                if (m_st[i] != 0 && m_addr[i] == int'(req_addr) && m_cmd[i] == int'(req_cmd)
                    && (ignore_tag || m_tag[i] == tg)) hit = i;
                if (m_st[i] == 0) frees = i;
                if (m_st[i] == 1) waits = i;
            end
            take = rd && hit >= 0 && m_st[hit] == 3;
            chk("rsp_done", rsp_done, (req_valid && req_write) || take);
            chk("rsp_retry", rsp_retry, rd && !take);
            chk("rsp_data_valid", rsp_data_valid, take);
            if (take) chk("rsp_data", rsp_data, m_data[hit]);
            chk("tag_err", tag_err, req_valid && bad);
            chk("discard_flag", discard_flag, m_disc);
            chk("be_req_valid", be_req_valid, waits >= 0);
            if (waits >= 0) chk("be_req_idx", be_req_idx, waits);
            n_disc = m_disc;
            for (int i = 0; i < DP; i++) begin
                n_st[i] = m_st[i]; n_addr[i] = m_addr[i]; n_cmd[i] = m_cmd[i];
                n_tag[i] = m_tag[i]; n_tmr[i] = m_tmr[i]; n_data[i] = m_data[i];
                if (m_st[i] == 3) begin
                    if (take && hit == i) n_st[i] = 0;
                    else if (m_tmr[i] == TO - 1) begin n_st[i] = 0; n_disc = 1; end
                    else n_tmr[i] = m_tmr[i] + 1;
                end
                if (m_st[i] == 2 && be_cpl_valid && int'(be_cpl_idx) == i) begin
                    n_st[i] = 3; n_data[i] = be_cpl_data; n_tmr[i] = 0;
                end
                if (m_st[i] == 1 && be_req_ready && waits == i) n_st[i] = 2;
                if (m_st[i] == 0 && rd && hit < 0 && frees == i) begin
                    n_st[i] = 1; n_addr[i] = int'(req_addr);
                    n_cmd[i] = int'(req_cmd); n_tag[i] = tg; n_tmr[i] = 0;
                end
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_disc = 0;
            for (int i = 0; i < DP; i++) begin
                m_st[i] = 0; m_addr[i] = 0; m_cmd[i] = 0; m_tag[i] = 0;
                m_tmr[i] = 0; m_data[i] = '0;
            end
        end else begin
            m_disc = n_disc;
            for (int i = 0; i < DP; i++) begin
                m_st[i] = n_st[i]; m_addr[i] = n_addr[i]; m_cmd[i] = n_cmd[i];
                m_tag[i] = n_tag[i]; m_tmr[i] = n_tmr[i]; m_data[i] = n_data[i];
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
        req_valid = 1'b0; req_write = 1'b0; be_cpl_valid = 1'b0; gnt_n = '1;
    endtask

    task automatic rd(input int a, input int c, input int m);
        req_valid = 1'b1; req_write = 1'b0;
        req_addr = AW'(a); req_cmd = CW'(c);
        gnt_n = ~(NM'(1) << m);
        tick();
    endtask

    task automatic rd_raw(input int a, input int c, input logic [NM-1:0] g);
        req_valid = 1'b1; req_write = 1'b0;
        req_addr = AW'(a); req_cmd = CW'(c); gnt_n = g;
        tick();
    endtask

    task automatic wr(input int a, input int m);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = AW'(a); req_cmd = CW'(7);
        gnt_n = ~(NM'(1) << m);
        tick();
    endtask

    task automatic cpl(input int idx, input logic [DW-1:0] d);
        be_cpl_valid = 1'b1; be_cpl_idx = 2'(idx); be_cpl_data = d;
        tick();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #8;
        lbl = "reset R10 R12";
        chk("reset discard_flag", discard_flag, 0);
        chk("reset be_req_valid", be_req_valid, 0);
        chk("reset rsp_done", rsp_done, 0);
        @(posedge clk); #2;

        lbl = "R1 R3 first read";   rd('h10, 6, 3);
        lbl = "R8 repeat pending";  rd('h10, 6, 3);
        lbl = "R12 second slot";    rd('h20, 6, 5);
        lbl = "R12 issue order";    be_req_ready = 1'b1; idle(2); be_req_ready = 1'b0;
        lbl = "R12 completions";    cpl(0, 32'hA5A5_0001); cpl(1, 32'h5A5A_0002);
        lbl = "R5 other tag";       rd('h10, 6, 7);
        lbl = "R7 write not blocked"; wr('h99, 7);
        lbl = "R4 claim";           rd('h10, 6, 3);
        lbl = "R11 freed after claim"; rd('h10, 6, 3);
        lbl = "R6 ignore tag";      ignore_tag = 1'b1; rd('h20, 6, 9); ignore_tag = 1'b0;
        lbl = "R9 fill table";      rd('h30, 2, 1); rd('h40, 2, 2);
        lbl = "R9 full";            rd('h50, 2, 4); rd('h50, 2, 4);
        lbl = "R12 drain";          be_req_ready = 1'b1; idle(4); be_req_ready = 1'b0;
        lbl = "R12 fill data";
        cpl(0, 32'h1111_0000); cpl(1, 32'h2222_0001);
        cpl(2, 32'h3333_0002); cpl(3, 32'h4444_0003);
        lbl = "R4 claim again";     rd('h10, 6, 3);
        lbl = "R2 two grants";      rd_raw('h60, 2, 16'hFFFC);
        lbl = "R2 tag zero used";   rd('h60, 2, 0);
        lbl = "R2 no grant";        rd_raw('h70, 2, '1);
        lbl = "R10 before expiry";  idle(20);
        chk("R10 discard still low", discard_flag, 0);
        lbl = "R10 expiry";         idle(30);
        chk("R10 discard sticky high", discard_flag, 1);
        lbl = "R10 after discard";  rd('h30, 2, 1);
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule